// File: doc/BRIEF.md
# Adder Carry-Chain Self-Test Sequencer

This block is a built-in test sequencer for a two-operand adder with a carry output. The adder is built from cascaded narrow slices and sits outside the block. After a start pulse, the sequencer applies one operand pair per clock to the adder's inputs. It reads back the sum and carry, and checks each result against a reference addition computed locally. The stimulus is not random and does not sweep all operand pairs. It is a fixed series of carry-stress phases aimed at the ripple paths between slices:

- a full-length carry;
- a carry that must stop at a single cleared bit;
- a carry launched from a single set bit into an all-ones word;
- sweeps of every value of one operand against zero and against each power of two;
- sweeps against every adjacent pair of set bits, so that each slice must add two ones plus an incoming carry.

Every operand pair is applied twice on consecutive cycles, first as A+B and then swapped as B+A. The carry-in stays at 0. A pipelined adder can be tested by setting the comparison delay. When the run ends, the block gives a one-cycle done pulse, a pass level, a saturating mismatch count and the first failing vector.

Top module: `adder_bist`

## Requirements
- R1: After reset, done is 0, err_count is 0, pass is 1, and dut_a, dut_b and dut_cin are all 0. While no run is active, dut_a and dut_b are 0.
- R2: A run applies five phases in this order, identified by the phase codes 1 to 5. All-ones is written ONES. (1) ONES with 1. (2) ONES with bit k cleared, with 1, for k rising from 0. (3) ONES with the one-hot value 1<<k, for k rising. (4) x with the addend, where the addend takes 0 first and then 1<<k for k rising; for each addend, x counts from 0 up to ONES. (5) x with 3<<k, for k from 0 to WIDTH-2, with x counting from 0 to ONES for each k. In every pair the first-named operand is the base and the second is the addend.
- R3: Each pair is driven for one cycle as dut_a=base, dut_b=addend, and on the next cycle as dut_a=addend, dut_b=base. A run is therefore 2+4·WIDTH+4·WIDTH·2^WIDTH cycles of vectors.
- R4: dut_cin is 0 at all times.
- R5: The result {dut_cout, dut_sum} is sampled LATENCY cycles after its vector is driven. It is compared with the reference dut_a+dut_b+dut_cin, taken as a (WIDTH+1)-bit value. When the adder is correct, a run ends with err_count 0.
- R6: Each mismatch adds one to err_count, which stops at 2^ERRW-1. An accepted start clears err_count.
- R7: The first mismatch of a run latches dut_a into fail_a, dut_b into fail_b, the phase code into fail_phase, and the observed sum and carry into fail_sum and fail_cout. Later mismatches leave these outputs unchanged.
- R8: done is high for exactly one cycle. It is high in the cycle that follows the rising edge (N+LATENCY) edges after the edge that samples start, where N is the vector count from R3.
- R9: A start pulse that arrives while a run is active, or while its results are still in flight, is ignored.
- R10: pass is high exactly when err_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| dut_a | output | WIDTH | Operand A to the adder under test |
| dut_b | output | WIDTH | Operand B to the adder under test |
| dut_cin | output | 1 | Carry-in to the adder under test, held 0 |
| dut_sum | input | WIDTH | Sum returned by the adder under test |
| dut_cout | input | 1 | Carry out returned by the adder under test |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | High when no mismatch has been counted |
| err_count | output | ERRW | Saturating mismatch count |
| fail_a | output | WIDTH | Operand A of the first mismatch |
| fail_b | output | WIDTH | Operand B of the first mismatch |
| fail_phase | output | 3 | Phase code of the first mismatch |
| fail_sum | output | WIDTH | Observed sum of the first mismatch |
| fail_cout | output | 1 | Observed carry of the first mismatch |

## Verification
The checker watches several properties on every clock:
- dut_cin stays at zero;
- each operand pair is followed at once by its swap;
- done lasts one cycle and never overlaps vector issue;
- err_count never decreases except on start, and holds once saturated;
- the first-failure record stays frozen once a mismatch is counted.

Some behaviour can only be shown by the bench scenarios. These are the exact order and content of the phase patterns, the alignment of a registered adder through the comparison delay, the latched fields of a deliberately broken carry path, the position of the done pulse, and the rejection of a start pulse in mid-run.

// File: rtl/adder_bist_pkg.sv
package adder_bist_pkg;

   // Phase codes; the numbering is visible on fail_phase.
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ALL1  = 3'd1,
      PH_ZERO  = 3'd2,
      PH_ONE   = 3'd3,
      PH_SWEEP = 3'd4,
      PH_PAIR  = 3'd5
   } phase_e;

endpackage

// File: rtl/adder_bist_gen.sv
module adder_bist_gen
   import adder_bist_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   output logic         vld,
   output logic         ord,
   output logic         last,
   output phase_e       phase,
   output logic [W-1:0] op_a,
   output logic [W-1:0] op_b
);

   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   logic         run;
   logic [W-1:0] walk;   // one-hot position shift register
   logic [W-1:0] x;      // sweep counter
   logic         zpat;   // sweep addend is zero
   logic [W-1:0] base, addend;

   assign vld  = run;
   assign last = run && ord && (phase == PH_PAIR) && (x == ONES) && walk[W-2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         ord   <= 1'b0;
         phase <= PH_IDLE;
         walk  <= ONE;
         x     <= '0;
         zpat  <= 1'b0;
      end else if (go) begin
         run   <= 1'b1;
         ord   <= 1'b0;
         phase <= PH_ALL1;
         walk  <= ONE;
         x     <= '0;
         zpat  <= 1'b0;
      end else if (run) begin
         ord <= ~ord;
         if (ord) begin
            unique case (phase)
               PH_ALL1: begin
                  phase <= PH_ZERO;
                  walk  <= ONE;
               end
               PH_ZERO, PH_ONE: begin
                  if (walk[W-1]) begin
                     phase <= (phase == PH_ZERO) ? PH_ONE : PH_SWEEP;
                     walk  <= ONE;
                     zpat  <= (phase == PH_ONE);
                     x     <= '0;
                  end else begin
                     walk <= walk << 1;
                  end
               end
               PH_SWEEP: begin
                  x <= x + ONE;
                  if (x == ONES) begin
                     if (zpat) begin
                        zpat <= 1'b0;
                     end else if (walk[W-1]) begin
                        phase <= PH_PAIR;
                        walk  <= ONE;
                     end else begin
                        walk <= walk << 1;
                     end
                  end
               end
               PH_PAIR: begin
                  x <= x + ONE;
                  if (x == ONES) begin
                     if (walk[W-2]) begin
                        run   <= 1'b0;
                        phase <= PH_IDLE;
                     end else begin
                        walk <= walk << 1;
                     end
                  end
               end
               default: run <= 1'b0;
            endcase
         end
      end
   end

   always_comb begin
      base   = '0;
      addend = '0;
      unique case (phase)
         PH_ALL1:  begin base = ONES;  addend = ONE;  end
         PH_ZERO:  begin base = ~walk; addend = ONE;  end
         PH_ONE:   begin base = ONES;  addend = walk; end
         PH_SWEEP: begin base = x;     addend = zpat ? '0 : walk; end
         PH_PAIR:  begin base = x;     addend = walk | (walk << 1); end
         default:  begin base = '0;    addend = '0;   end
      endcase
   end

   assign op_a = !run ? '0 : (ord ? addend : base);
   assign op_b = !run ? '0 : (ord ? base : addend);

endmodule

// File: rtl/adder_bist_cmp.sv
module adder_bist_cmp
   import adder_bist_pkg::*;
#(
   parameter int W    = 16,
   parameter int LAT  = 0,
   parameter int ERRW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            in_vld,
   input  logic            in_last,
   input  phase_e          in_phase,
   input  logic [W-1:0]    in_a,
   input  logic [W-1:0]    in_b,
   input  logic            cin,
   input  logic [W-1:0]    obs_sum,
   input  logic            obs_cout,
   output logic            done,
   output logic            busy_tail,
   output logic [ERRW-1:0] err_count,
   output logic [W-1:0]    fail_a,
   output logic [W-1:0]    fail_b,
   output logic [2:0]      fail_phase,
   output logic [W-1:0]    fail_sum,
   output logic            fail_cout
);

   localparam logic [ERRW-1:0] ERR_MAX = '1;

   typedef struct packed {
      logic         vld;
      logic         last;
      logic [2:0]   ph;
      logic [W-1:0] a;
      logic [W-1:0] b;
   } stage_t;

   stage_t inp, d;
   logic [W:0] ref_sum;
   logic       mism;

   assign inp = '{vld: in_vld, last: in_last, ph: in_phase, a: in_a, b: in_b};

   generate
      if (LAT == 0) begin : g_direct
         assign d         = inp;
         assign busy_tail = 1'b0;
      end else begin : g_pipe
         stage_t      pipe [LAT];
         logic [LAT-1:0] occ;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= inp;
               for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
            end
         end
         for (genvar i = 0; i < LAT; i++) begin : g_occ
            assign occ[i] = pipe[i].vld;
         end
         assign d         = pipe[LAT-1];
         assign busy_tail = |occ;
      end
   endgenerate

   assign ref_sum = {1'b0, d.a} + {1'b0, d.b} + {{W{1'b0}}, cin};
   assign mism    = d.vld && ({obs_cout, obs_sum} != ref_sum);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         err_count  <= '0;
         fail_a     <= '0;
         fail_b     <= '0;
         fail_phase <= '0;
         fail_sum   <= '0;
         fail_cout  <= 1'b0;
      end else begin
         done <= d.vld && d.last;
         if (clr) begin
            err_count <= '0;
         end else if (mism) begin
            if (err_count == '0) begin
               fail_a     <= d.a;
               fail_b     <= d.b;
               fail_phase <= d.ph;
               fail_sum   <= obs_sum;
               fail_cout  <= obs_cout;
            end
            if (err_count != ERR_MAX) err_count <= err_count + 1'b1;
         end
      end
   end

endmodule

// File: rtl/adder_bist.sv
module adder_bist
   import adder_bist_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter int LATENCY = 0,
   parameter int ERRW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [WIDTH-1:0] dut_a,
   output logic [WIDTH-1:0] dut_b,
   output logic             dut_cin,
   input  logic [WIDTH-1:0] dut_sum,
   input  logic             dut_cout,
   output logic             done,
   output logic             pass,
   output logic [ERRW-1:0]  err_count,
   output logic [WIDTH-1:0] fail_a,
   output logic [WIDTH-1:0] fail_b,
   output logic [2:0]       fail_phase,
   output logic [WIDTH-1:0] fail_sum,
   output logic             fail_cout
);

   generate
      if (WIDTH < 2)   begin : g_bad_w   $error("adder_bist: WIDTH must be at least 2");   end
      if (LATENCY < 0) begin : g_bad_lat $error("adder_bist: LATENCY must not be negative"); end
      if (ERRW < 1)    begin : g_bad_ew  $error("adder_bist: ERRW must be at least 1");    end
   endgenerate

   logic   busy, go, busy_tail;
   logic   issue_vld, issue_ord, issue_last;
   phase_e issue_phase;

   assign go      = start && !busy;
   assign dut_cin = 1'b0;
   assign pass    = (err_count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    busy <= 1'b0;
      else if (go)   busy <= 1'b1;
      else if (busy && !issue_vld && !busy_tail && !done) busy <= 1'b0;
   end

   adder_bist_gen #(.W(WIDTH)) i_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .vld   (issue_vld),
      .ord   (issue_ord),
      .last  (issue_last),
      .phase (issue_phase),
      .op_a  (dut_a),
      .op_b  (dut_b)
   );

   adder_bist_cmp #(.W(WIDTH), .LAT(LATENCY), .ERRW(ERRW)) i_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (go),
      .in_vld     (issue_vld),
      .in_last    (issue_last),
      .in_phase   (issue_phase),
      .in_a       (dut_a),
      .in_b       (dut_b),
      .cin        (dut_cin),
      .obs_sum    (dut_sum),
      .obs_cout   (dut_cout),
      .done       (done),
      .busy_tail  (busy_tail),
      .err_count  (err_count),
      .fail_a     (fail_a),
      .fail_b     (fail_b),
      .fail_phase (fail_phase),
      .fail_sum   (fail_sum),
      .fail_cout  (fail_cout)
   );

endmodule

// File: rtl/adder_bist_chk.sv
module adder_bist_chk #(
   parameter int W  = 16,
   parameter int EW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [W-1:0]  dut_a,
   input logic [W-1:0]  dut_b,
   input logic          dut_cin,
   input logic          done,
   input logic [EW-1:0] err_count,
   input logic [W-1:0]  fail_a,
   input logic [W-1:0]  fail_b,
   input logic          issue_vld,
   input logic          issue_ord
);

   localparam logic [EW-1:0] EMAX = '1;

   p_cin_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dut_cin == 1'b0);

   p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !issue_ord) |=>
         (issue_vld && issue_ord && dut_a == $past(dut_b) && dut_b == $past(dut_a)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !issue_vld);

   p_err_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (err_count >= $past(err_count)));

   p_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == EMAX && !start) |=> (err_count == EMAX));

   p_first_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != '0 && !start) |=> ($stable(fail_a) && $stable(fail_b)));

endmodule

bind adder_bist adder_bist_chk #(.W(WIDTH), .EW(ERRW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dut_a     (dut_a),
   .dut_b     (dut_b),
   .dut_cin   (dut_cin),
   .done      (done),
   .err_count (err_count),
   .fail_a    (fail_a),
   .fail_b    (fail_b),
   .issue_vld (issue_vld),
   .issue_ord (issue_ord)
);

// File: tb/test_adder_bist.sv
module test_adder_bist;

   localparam int W   = 8;
   localparam int LAT = 1;
   localparam int EW  = 4;
   localparam int EMAX = (1 << EW) - 1;
   localparam logic [W-1:0] ONES = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  dut_a, dut_b, dut_sum, fail_a, fail_b, fail_sum;
   logic          dut_cin, dut_cout, done, pass, fail_cout;
   logic [EW-1:0] err_count;
   logic [2:0]    fail_phase;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit fault_on = 1'b0;

   logic [W-1:0] qa[$];
   logic [W-1:0] qb[$];
   int           qp[$];

   always #2 clk = ~clk;   // 250 MHz

   adder_bist #(.WIDTH(W), .LATENCY(LAT), .ERRW(EW)) i_adder_bist (
      .clk, .rst_n, .start, .dut_a, .dut_b, .dut_cin, .dut_sum, .dut_cout,
      .done, .pass, .err_count, .fail_a, .fail_b, .fail_phase, .fail_sum, .fail_cout
   );

   // Adder under test: registered (one cycle), with an optional broken carry at bit 3.
   function automatic logic [W:0] model_add(logic [W-1:0] a, logic [W-1:0] b, logic ci, bit flt);
      logic [W:0] r;
      r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      if (flt && a[3] && b[3]) r = r ^ (W+1)'(1 << 4);
      return r;
   endfunction

   always_ff @(posedge clk) {dut_cout, dut_sum} <= model_add(dut_a, dut_b, dut_cin, fault_on);

   task automatic finish_test();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_test();
      end
   end

   task automatic check(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_pair(logic [W-1:0] base, logic [W-1:0] add, int ph);
      qa.push_back(base); qb.push_back(add); qp.push_back(ph);
      qa.push_back(add);  qb.push_back(base); qp.push_back(ph);
   endtask

   // Behavioural vector list from R2/R3.
   task automatic build_vectors();
      push_pair(ONES, 1, 1);
      for (int k = 0; k < W; k++) push_pair(~(W'(1) << k), 1, 2);
      for (int k = 0; k < W; k++) push_pair(ONES, W'(1) << k, 3);
      for (int j = 0; j <= W; j++)
         for (int x = 0; x < (1 << W); x++)
            push_pair(W'(x), (j == 0) ? '0 : (W'(1) << (j-1)), 4);
      for (int k = 0; k < W-1; k++)
         for (int x = 0; x < (1 << W); x++)
            push_pair(W'(x), W'(3) << k, 5);
   endtask

   task automatic run_once(bit flt, int extra_start_at);
      int n, exp_err, first;
      logic [W:0] obs;
      int vec_bad;
      fault_on = flt;
      n = qa.size();
      exp_err = 0; first = -1;
      for (int i = 0; i < n; i++) begin
         if (model_add(qa[i], qb[i], 1'b0, flt) != ({1'b0, qa[i]} + {1'b0, qb[i]})) begin
            if (first < 0) first = i;
            exp_err++;
         end
      end
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      vec_bad = 0;
      for (int i = 0; i < n; i++) begin
         // R2 R3: operand stream, R4: carry-in held low, R8: no early done
         if (dut_a !== qa[i] || dut_b !== qb[i]) begin
            vec_bad++;
            if (vec_bad < 5) check(0, "R2/R3 vector", {dut_a, dut_b}, {qa[i], qb[i]});
         end
         if (dut_cin !== 1'b0) check(0, "R4 cin", dut_cin, 0);
         if (done !== 1'b0) check(0, "R8 early done", done, 0);
         if (i == extra_start_at) start = 1'b1;   // R9: must be ignored
         @(negedge clk) start = 1'b0;
      end
      check(vec_bad == 0, "R2 R3 whole stream", vec_bad, 0);
      check(vec_bad == 0, "R9 start in mid-run ignored", vec_bad, 0);
      // After edge E0+N: done expected after E0+N+LAT
      for (int l = 0; l < LAT; l++) begin
         check(done === 1'b0, "R8 done not yet", done, 0);
         @(negedge clk);
      end
      check(done === 1'b1, "R8 done pulse", done, 1);
      check(dut_a === '0 && dut_b === '0, "R1 idle operands", {dut_a, dut_b}, 0);
      if (exp_err > EMAX) exp_err = EMAX;
      check(err_count == EW'(exp_err), "R5 R6 err_count", err_count, exp_err);
      check(pass == (exp_err == 0), "R10 pass", pass, exp_err == 0);
      if (first >= 0) begin
         obs = model_add(qa[first], qb[first], 1'b0, flt);
         check(fail_a == qa[first], "R7 fail_a", fail_a, qa[first]);
         check(fail_b == qb[first], "R7 fail_b", fail_b, qb[first]);
         check(fail_phase == 3'(qp[first]), "R7 fail_phase", fail_phase, qp[first]);
         check({fail_cout, fail_sum} == obs, "R7 fail result", {fail_cout, fail_sum}, obs);
      end
      @(negedge clk);
      check(done === 1'b0, "R8 single-cycle done", done, 0);
      @(negedge clk);
   endtask

   initial begin
      build_vectors();
      check(qa.size() == 2 + 4*W + 4*W*(1 << W), "R3 vector count", qa.size(), 2 + 4*W + 4*W*(1 << W));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(done === 1'b0, "R1 done", done, 0);
      check(err_count === '0, "R1 err_count", err_count, 0);
      check(pass === 1'b1, "R1 pass", pass, 1);
      check(dut_a === '0 && dut_b === '0, "R1 operands", {dut_a, dut_b}, 0);
      check(dut_cin === 1'b0, "R1 R4 cin", dut_cin, 0);
      run_once(1'b0, -1);    // R5 clean adder, aligned through LATENCY
      run_once(1'b1, 100);   // R6 saturation, R7 first failure, R9 ignored start
      run_once(1'b0, 5000);  // R6 cleared by start
      finish_test();
   end

endmodule